// File: doc/BRIEF.md
# Dual-Port Four-Bank Interleaved Data Array

This block is the data store of a first-level data cache, cut into four independent banks so that two load/store requests can complete in the same clock. Each 64-byte block goes to one bank, picked by the block number taken modulo four. Successive blocks therefore land in successive banks, and streaming or neighbouring accesses from the two ports usually touch different banks.

Each request port has a valid, a byte address, a write enable and write data. A ready output is high in the cycle its request is accepted. If both ports aim at the same bank in one cycle, one of them is accepted and the other sees ready low. The port that lost then holds priority for the next conflict. Read data returns on the accepting port's own response pins one cycle after acceptance. Tag compare and miss handling sit elsewhere; each bank here is a plain single-ported word array holding one data word per block.

Top module: `interleaved_l1_banks`

## Requirements
- R1: With the default parameters the bank of a request is byte address bits [7:6], so consecutive 64-byte blocks go to banks 0,1,2,3,0,... and the row inside the bank is address bits [11:8]. Address bits [5:0] select nothing, so any byte offset within a block reaches the same word.
- R2: While reset is held and in the first cycle after it, both response valids are low. A port with no valid request never shows ready high.
- R3: Two valid requests that map to different banks are both accepted (both readies high) in the same cycle.
- R4: A valid request on one port while the other port is idle is always accepted.
- R5: When both valid requests map to the same bank, exactly one ready is high.
- R6: Conflict priority starts at port A after reset. After every conflict it passes to the port that lost. Cycles without a conflict leave it unchanged.
- R7: A port refused because of a conflict that presents a request again in the next cycle is accepted in that cycle.
- R8: An accepted read raises that port's response valid one cycle later, with the addressed word on that port's read data. Accepted writes and idle cycles produce no response valid.
- R9: An accepted write stores its data at the addressed bank and row, and a later read of that word returns it. A write refused with ready low changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_valid | input | 1 | Port A request present |
| pa_addr | input | ADDR_W (12) | Port A byte address |
| pa_we | input | 1 | Port A write (1) or read (0) |
| pa_wdata | input | DATA_W (32) | Port A write data |
| pa_ready | output | 1 | Port A request accepted this cycle |
| pa_rvalid | output | 1 | Port A read response valid |
| pa_rdata | output | DATA_W (32) | Port A read data |
| pb_valid | input | 1 | Port B request present |
| pb_addr | input | ADDR_W (12) | Port B byte address |
| pb_we | input | 1 | Port B write (1) or read (0) |
| pb_wdata | input | DATA_W (32) | Port B write data |
| pb_ready | output | 1 | Port B request accepted this cycle |
| pb_rvalid | output | 1 | Port B read response valid |
| pb_rdata | output | DATA_W (32) | Port B read data |

## Verification
The bench builds the block with its defaults: four banks, 64-byte blocks, 16 rows per bank and 32-bit data, which gives a 12-bit address. With only 64 words in total, every row of every bank can be written and read back through both ports. Same-bank pairs are also easy to produce, which gives repeated conflicts to exercise priority handover, refused writes and the re-presented request. Offset bits sit directly below the bank bits, so changing only the byte offset checks that it has no effect on which word is reached.

// File: rtl/ilb_pkg.sv
package ilb_pkg;

  // Which bank a byte address falls into: block number modulo bank count.
  function automatic logic [7:0] bank_sel(input logic [31:0] byte_addr,
                                          input int offs_w, input int bank_w);
    logic [31:0] blk;
    blk = byte_addr >> offs_w;
    return 8'(blk & ((32'd1 << bank_w) - 32'd1));
  endfunction

  // Row inside the bank: the block number with the bank bits stripped.
  function automatic logic [15:0] row_sel(input logic [31:0] byte_addr,
                                          input int offs_w, input int bank_w);
    return 16'(byte_addr >> (offs_w + bank_w));
  endfunction

  // Next priority holder: the loser of a conflict gains priority.
  function automatic logic next_pri(input logic pri, input logic clash);
    return clash ? ~pri : pri;
  endfunction

endpackage

// File: rtl/ilb_arbiter.sv
module ilb_arbiter #(
  parameter int ADDR_W = 12,
  parameter int OFFS_W = 6,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             vld,
  input  logic [1:0][ADDR_W-1:0] addr,
  output logic [1:0]             gnt,
  output logic [1:0][BANK_W-1:0] bank,
  output logic [1:0][ROW_W-1:0]  row,
  output logic                   conflict
);

  logic pri_q;      // 0: port A wins a conflict, 1: port B wins
  logic same_bank;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_decode
      always_comb begin
        bank[p] = BANK_W'(ilb_pkg::bank_sel(32'(addr[p]), OFFS_W, BANK_W));
        row[p]  = ROW_W'(ilb_pkg::row_sel(32'(addr[p]), OFFS_W, BANK_W));
      end
    end
  endgenerate

  assign same_bank = (bank[0] == bank[1]);
  assign conflict  = vld[0] & vld[1] & same_bank;
  assign gnt[0]    = vld[0] & ~(conflict & pri_q);
  assign gnt[1]    = vld[1] & ~(conflict & ~pri_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pri_q <= 1'b0;
    else        pri_q <= ilb_pkg::next_pri(pri_q, conflict);
  end

  // R3: different banks, both valid -> both granted
  assert_diff_bank_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld[0] && vld[1] && (bank[0] != bank[1])) |-> (gnt == 2'b11));

  // R4: lone request is granted
  assert_lone_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld[0] ^ vld[1])) |-> (gnt == vld));

  // R5: same bank -> exactly one grant
  assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> ($countones(gnt) == 1));

  // R2: no grant without a request
  assert_no_idle_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~vld) == 2'b00));

  // R7: a refused port that asks again is served next cycle
  assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !gnt[0]) |=> (!vld[0] || gnt[0]));
  assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !gnt[1]) |=> (!vld[1] || gnt[1]));

endmodule

// File: rtl/ilb_bank.sv
module ilb_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 16,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en && we)  mem[row] <= wdata;
    if (en && !we) rdata    <= mem[row];
  end

endmodule

// File: rtl/ilb_rsp_route.sv
module ilb_rsp_route #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        gnt,
  input  logic [1:0]                        we,
  input  logic [1:0][BANK_W-1:0]            bank,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata,
  output logic [1:0]                        rvalid,
  output logic [1:0][DATA_W-1:0]            rdata
);

  logic [1:0]             rd_q;
  logic [1:0][BANK_W-1:0] src_q;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q[p]  <= 1'b0;
          src_q[p] <= '0;
        end else begin
          rd_q[p] <= gnt[p] & ~we[p];
          if (gnt[p] && !we[p]) src_q[p] <= bank[p];
        end
      end
      assign rvalid[p] = rd_q[p];
      assign rdata[p]  = bank_rdata[src_q[p]];
    end
  endgenerate

  // R8: write grants never produce a response
  assert_no_write_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && we[0]) |=> !rvalid[0]);

endmodule

// File: rtl/interleaved_l1_banks.sv
module interleaved_l1_banks #(
  parameter int  DATA_W      = 32,
  parameter int  NUM_BANKS   = 4,
  parameter int  BLOCK_BYTES = 64,
  parameter int  BANK_ROWS   = 16,
  localparam int OFFS_W      = $clog2(BLOCK_BYTES),
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int ROW_W       = $clog2(BANK_ROWS),
  localparam int ADDR_W      = OFFS_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pa_valid,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic              pa_we,
  input  logic [DATA_W-1:0] pa_wdata,
  output logic              pa_ready,
  output logic              pa_rvalid,
  output logic [DATA_W-1:0] pa_rdata,
  input  logic              pb_valid,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic              pb_we,
  input  logic [DATA_W-1:0] pb_wdata,
  output logic              pb_ready,
  output logic              pb_rvalid,
  output logic [DATA_W-1:0] pb_rdata
);

  logic [1:0]                       vld, we, gnt, rvalid;
  logic [1:0][ADDR_W-1:0]           addr;
  logic [1:0][DATA_W-1:0]           wdata, rdata;
  logic [1:0][BANK_W-1:0]           bank;
  logic [1:0][ROW_W-1:0]            row;
  logic                             conflict;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [NUM_BANKS-1:0]             hit_a, hit_b;

  assign vld   = {pb_valid, pa_valid};
  assign we    = {pb_we, pa_we};
  assign addr  = {pb_addr, pa_addr};
  assign wdata = {pb_wdata, pa_wdata};

  ilb_arbiter #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .vld(vld), .addr(addr),
    .gnt(gnt), .bank(bank), .row(row), .conflict(conflict)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic              en, bwe;
      logic [ROW_W-1:0]  brow;
      logic [DATA_W-1:0] bwdata;

      assign hit_a[b] = gnt[0] && (bank[0] == BANK_W'(b));
      assign hit_b[b] = gnt[1] && (bank[1] == BANK_W'(b));
      assign en       = hit_a[b] | hit_b[b];
      assign bwe      = hit_b[b] ? we[1]    : we[0];
      assign brow     = hit_b[b] ? row[1]   : row[0];
      assign bwdata   = hit_b[b] ? wdata[1] : wdata[0];

      ilb_bank #(.DATA_W(DATA_W), .ROWS(BANK_ROWS), .ROW_W(ROW_W)) bank_i (
        .clk(clk), .en(en), .we(bwe), .row(brow), .wdata(bwdata), .rdata(bank_rdata[b])
      );

      // R5: a bank is never driven by both ports in one cycle
      assert_bank_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_a[b], hit_b[b]}));
    end
  endgenerate

  ilb_rsp_route #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .DATA_W(DATA_W)) rsp_i (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .we(we), .bank(bank),
    .bank_rdata(bank_rdata), .rvalid(rvalid), .rdata(rdata)
  );

  assign pa_ready  = gnt[0];
  assign pb_ready  = gnt[1];
  assign pa_rvalid = rvalid[0];
  assign pb_rvalid = rvalid[1];
  assign pa_rdata  = rdata[0];
  assign pb_rdata  = rdata[1];

  // R8: an accepted read on port B answers in the next cycle
  assert_read_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_ready && !pb_we) |=> pb_rvalid);

  // R6: priority passes from A to B after a conflict A won
  assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && pa_ready) |=> (!conflict || pb_ready));

endmodule

// File: tb/interleaved_l1_banks_tb_top.sv
module interleaved_l1_banks_tb_top;

  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pa_valid = 1'b0, pa_we = 1'b0, pb_valid = 1'b0, pb_we = 1'b0;
  logic [AW-1:0] pa_addr = '0, pb_addr = '0;
  logic [DW-1:0] pa_wdata = '0, pb_wdata = '0;
  logic          pa_ready, pa_rvalid, pb_ready, pb_rvalid;
  logic [DW-1:0] pa_rdata, pb_rdata;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic tb_pri = 1'b0;
  logic [DW-1:0] mdl [4][16];

  always #10 clk = ~clk;  // 50 MHz

  interleaved_l1_banks dut_i (
    .clk(clk), .rst_n(rst_n),
    .pa_valid(pa_valid), .pa_addr(pa_addr), .pa_we(pa_we), .pa_wdata(pa_wdata),
    .pa_ready(pa_ready), .pa_rvalid(pa_rvalid), .pa_rdata(pa_rdata),
    .pb_valid(pb_valid), .pb_addr(pb_addr), .pb_we(pb_we), .pb_wdata(pb_wdata),
    .pb_ready(pb_ready), .pb_rvalid(pb_rvalid), .pb_rdata(pb_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R1 layout: row in [11:8], bank in [7:6], offset in [5:0]
  function automatic logic [AW-1:0] mk(input int bank, input int row, input int offs);
    return {4'(row), 2'(bank), 6'(offs)};
  endfunction

  function automatic logic [DW-1:0] pat(input int bank, input int row, input int salt);
    return 32'hC000_0000 + 32'(salt << 16) + 32'(bank << 8) + 32'(row);
  endfunction

  // One clock of stimulus with expected ready/response computed from the requirements
  task automatic step(input string req,
                      input logic v0, input logic [AW-1:0] a0, input logic w0, input logic [DW-1:0] d0,
                      input logic v1, input logic [AW-1:0] a1, input logic w1, input logic [DW-1:0] d1);
    int b0, r0, b1, r1;
    logic c, g0, g1;
    logic [DW-1:0] e0, e1;
    b0 = int'(a0[7:6]); r0 = int'(a0[11:8]);
    b1 = int'(a1[7:6]); r1 = int'(a1[11:8]);
    c  = v0 && v1 && (b0 == b1);
    g0 = v0 && !(c && tb_pri);
    g1 = v1 && !(c && !tb_pri);
    if (c) tb_pri = !tb_pri;
    e0 = mdl[b0][r0];
    e1 = mdl[b1][r1];
    @(negedge clk);
    pa_valid = v0; pa_addr = a0; pa_we = w0; pa_wdata = d0;
    pb_valid = v1; pb_addr = a1; pb_we = w1; pb_wdata = d1;
    #2;
    chk(pa_ready == g0, {req, " ready A"}, 64'(pa_ready), 64'(g0));
    chk(pb_ready == g1, {req, " ready B"}, 64'(pb_ready), 64'(g1));
    @(posedge clk);
    #3;
    chk(pa_rvalid == (g0 && !w0), {req, " R8 rvalid A"}, 64'(pa_rvalid), 64'(g0 && !w0));
    chk(pb_rvalid == (g1 && !w1), {req, " R8 rvalid B"}, 64'(pb_rvalid), 64'(g1 && !w1));
    if (g0 && !w0) chk(pa_rdata == e0, {req, " R8 rdata A"}, 64'(pa_rdata), 64'(e0));
    if (g1 && !w1) chk(pb_rdata == e1, {req, " R8 rdata B"}, 64'(pb_rdata), 64'(e1));
    if (g0 && w0) mdl[b0][r0] = d0;
    if (g1 && w1) mdl[b1][r1] = d1;
  endtask

  task automatic idle();
    step("idle R2", 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_reset();
    #3;
    chk(pa_rvalid == 1'b0, "R2 rvalid A in reset", 64'(pa_rvalid), 0);
    chk(pb_rvalid == 1'b0, "R2 rvalid B in reset", 64'(pb_rvalid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #3;
    chk(pa_rvalid == 1'b0, "R2 rvalid A after reset", 64'(pa_rvalid), 0);
    chk(pb_ready == 1'b0, "R2 ready B with no request", 64'(pb_ready), 0);
  endtask

  // R3, R9: fill every word with two writes per cycle to different banks
  task automatic t_fill();
    for (int r = 0; r < 16; r++) begin
      step("R3 R9 fill", 1'b1, mk(0, r, r), 1'b1, pat(0, r, 1), 1'b1, mk(1, r, 63 - r), 1'b1, pat(1, r, 1));
      step("R3 R9 fill", 1'b1, mk(3, r, 0), 1'b1, pat(3, r, 1), 1'b1, mk(2, r, 5), 1'b1, pat(2, r, 1));
    end
  endtask

  // R3, R8, R1: parallel reads from differing banks and offsets
  task automatic t_par_read();
    for (int r = 0; r < 16; r++)
      step("R3 R1 read", 1'b1, mk(r % 4, r, 7), 1'b0, '0, 1'b1, mk((r + 1) % 4, 15 - r, 60), 1'b0, '0);
    step("R3 read+write", 1'b1, mk(2, 4, 0), 1'b0, '0, 1'b1, mk(1, 9, 0), 1'b1, pat(1, 9, 2));
  endtask

  // R1: only the offset differs -> same word
  task automatic t_offset();
    step("R1 offset 0", 1'b1, mk(1, 6, 0), 1'b0, '0, 1'b0, '0, 1'b0, '0);
    step("R1 offset 63", 1'b1, mk(1, 6, 63), 1'b0, '0, 1'b0, '0, 1'b0, '0);
    step("R1 offset 33 on B", 1'b0, '0, 1'b0, '0, 1'b1, mk(1, 6, 33), 1'b0, '0);
  endtask

  // R5, R6, R7: conflicts rotate and refused port is served next cycle
  task automatic t_conflict();
    step("R5 R6 first conflict A wins", 1'b1, mk(2, 1, 0), 1'b0, '0, 1'b1, mk(2, 3, 0), 1'b0, '0);
    step("R7 B re-presented", 1'b0, '0, 1'b0, '0, 1'b1, mk(2, 3, 0), 1'b0, '0);
    step("R6 second conflict B wins", 1'b1, mk(0, 5, 0), 1'b0, '0, 1'b1, mk(0, 7, 0), 1'b0, '0);
    step("R7 A re-presented", 1'b1, mk(0, 5, 0), 1'b0, '0, 1'b0, '0, 1'b0, '0);
    step("R4 lone B", 1'b0, '0, 1'b0, '0, 1'b1, mk(3, 2, 0), 1'b0, '0);
    step("R6 third conflict A wins", 1'b1, mk(3, 8, 0), 1'b0, '0, 1'b1, mk(3, 8, 9), 1'b0, '0);
    step("R7 B kept asking", 1'b1, mk(0, 0, 0), 1'b0, '0, 1'b1, mk(3, 8, 9), 1'b0, '0);
  endtask

  // R9: refused write leaves memory untouched; write then read
  task automatic t_refused_write();
    step("R9 conflicting writes", 1'b1, mk(1, 12, 0), 1'b1, pat(1, 12, 7), 1'b1, mk(1, 12, 0), 1'b1, pat(1, 12, 8));
    step("R9 read after refused write", 1'b1, mk(1, 12, 0), 1'b0, '0, 1'b0, '0, 1'b0, '0);
    step("R9 write B", 1'b0, '0, 1'b0, '0, 1'b1, mk(2, 13, 0), 1'b1, pat(2, 13, 9));
    step("R9 read back on A", 1'b1, mk(2, 13, 1), 1'b0, '0, 1'b0, '0, 1'b0, '0);
    chk(pa_rdata == pat(2, 13, 9), "R9 stored value", 64'(pa_rdata), 64'(pat(2, 13, 9)));
  endtask

  initial begin
    t_reset();
    t_fill();
    idle();
    t_par_read();
    t_offset();
    t_conflict();
    t_refused_write();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule